// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Periodic Tick

This block is a timer peripheral. It holds a 40-bit real-time counter that advances by one on every clock and is read as two words: a narrow upper word and a 32-bit lower word. Beside the counter sits a 40-bit alarm comparator and a reloadable periodic down-counter that produces a regular tick. Software uses one small register interface to control all three. Through that interface it can stop either half of the counter, clear the counter, run or pause the periodic timer, program the alarm, and read and acknowledge the three event flags.

Three events are recorded in sticky flags: the counter wrapping past its all-ones value, the counter reaching the committed alarm value, and the periodic timer running out. Each flag stays set until software writes a one to it. A mask register picks which flags drive the single interrupt output. The alarm is written in two steps. The upper part is held in staging, and writing the lower part commits the whole value, so the comparator never works on a half-written value. Reading the lower counter word captures the upper word at the same moment. A following upper-word read therefore returns a value that is coherent with that lower read.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset, every register reads as zero, all flags are clear, `irq` is low, the periodic timer is disabled and the alarm is disarmed.
- R2: With control at zero, the counter grows by exactly one each clock. The low word reads at address 2 in bits [LO_W-1:0]. Low-word reads taken k clocks apart differ by k, modulo 2^LO_W.
- R3: Control bit 1 freezes the low word, which then also stops carries into the high word. Control bit 2 freezes the high word while the low word keeps counting and wrapping.
- R4: Control bit 0 forces the whole counter to zero and holds it there. The counter reads 0 on the first clock after the bit is cleared and then counts on from there.
- R5: Status bit 31 sets on the clock at which the full counter wraps from all ones to zero.
- R6: A write to address 3 only stages the alarm's upper bits. A write to address 4 commits {staged upper, written lower} and arms the comparator. Status bit 30 sets on the clock after the armed alarm equals the counter.
- R7: Address 5 holds the reload value N. With control bit 3 set, status bit 29 sets once every N+1 clocks, first N+1 clocks after enabling. Control bit 4 pauses the down-counter without reloading it.
- R8: Writing zero to the control register disables the periodic timer, releases both freezes and lets the counter run.
- R9: Writing one to status bits 31..29 at address 6 clears the matching flags; otherwise flags stay set. An event in the same clock as its clear wins.
- R10: `irq` is high exactly when some flag is set whose enable bit (bits 31..29 at address 7) is set.
- R11: A low-word read latches the high word into a shadow. Address 1 returns that shadow in bits [HI_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (only has a side effect for the low word) |
| addr | input | 3 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Masked OR of the event flags |

## Verification
Two things can land on the same clock edge: the periodic timer setting its flag, and a software write-one-to-clear of that same flag. The bench provokes this by loading a reload value of zero, so the timer fires on every clock. It then issues the clear and reads the status on the next cycle, expecting the flag to still be set because the event must win. A separate scenario with a longer period checks that a clear issued away from any event does drop the flag, so that the precedence check is not a flag stuck at one.

// File: rtl/rtat_pkg.sv
package rtat_pkg;

   localparam int BUS_W     = 32;
   localparam int NUM_FLAGS = 3;
   // flag index i lives at status / enable bit (FLAG_LSB + i)
   localparam int FLAG_LSB  = 29;
   localparam int F_TICK    = 0;
   localparam int F_ALARM   = 1;
   localparam int F_WRAP    = 2;

   typedef enum logic [2:0] {
      A_CTRL   = 3'd0,
      A_CNT_HI = 3'd1,
      A_CNT_LO = 3'd2,
      A_ALM_HI = 3'd3,
      A_ALM_LO = 3'd4,
      A_RELOAD = 3'd5,
      A_STATUS = 3'd6,
      A_IRQEN  = 3'd7
   } reg_addr_e;

   typedef struct packed {
      logic per_hold;   // bit 4
      logic per_run;    // bit 3
      logic hold_hi;    // bit 2
      logic hold_lo;    // bit 1
      logic zero;       // bit 0
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/rtat_rtc_counter.sv
module rtat_rtc_counter #(
   parameter int HI_W = 8,
   parameter int LO_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            zero,
   input  logic            hold_lo,
   input  logic            hold_hi,
   output logic [HI_W-1:0] cnt_hi,
   output logic [LO_W-1:0] cnt_lo,
   output logic            wrap
);

   logic lo_carry;
   logic hi_step;

   assign lo_carry = !hold_lo && (&cnt_lo);
   assign hi_step  = lo_carry && !hold_hi;
   assign wrap     = !zero && hi_step && (&cnt_hi);

   always_ff @(posedge clk) begin
      if (!rst_n || zero) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else begin
         if (!hold_lo) cnt_lo <= cnt_lo + 1'b1;
         if (hi_step)  cnt_hi <= cnt_hi + 1'b1;
      end
   end

endmodule

// File: rtl/rtat_alarm_cmp.sv
module rtat_alarm_cmp #(
   parameter int HI_W = 8,
   parameter int LO_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stage_hi,
   input  logic            commit_lo,
   input  logic [HI_W-1:0] wr_hi,
   input  logic [LO_W-1:0] wr_lo,
   input  logic [HI_W-1:0] cnt_hi,
   input  logic [LO_W-1:0] cnt_lo,
   output logic            hit
);

   localparam int FULL_W = HI_W + LO_W;

   logic [HI_W-1:0]   staged_q;
   logic [FULL_W-1:0] target_q;
   logic              armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         staged_q <= '0;
         target_q <= '0;
         armed_q  <= 1'b0;
      end else begin
         if (stage_hi)  staged_q <= wr_hi;
         if (commit_lo) begin
            target_q <= {staged_q, wr_lo};
            armed_q  <= 1'b1;
         end
      end
   end

   assign hit = armed_q && (target_q == {cnt_hi, cnt_lo});

endmodule

// File: rtl/rtat_periodic.sv
module rtat_periodic #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic [PER_W-1:0] reload,
   output logic [PER_W-1:0] cnt,
   output logic             tick
);

   logic at_zero;

   assign at_zero = (cnt == '0);
   assign tick    = run && !hold && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= reload;
      end else if (!hold) begin
         cnt <= at_zero ? reload : cnt - 1'b1;
      end
   end

endmodule

// File: rtl/rtat_irq_flags.sv
module rtat_irq_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] ack,
   input  logic [N-1:0] enable,
   output logic [N-1:0] flags,
   output logic         irq
);

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) flags[i] <= 1'b0;
         else        flags[i] <= set[i] | (flags[i] & ~ack[i]);
      end
   end

   assign irq = |(flags & enable);

endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer #(
   parameter int HI_W  = 8,
   parameter int LO_W  = 32,
   parameter int PER_W = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [2:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        irq
);
   import rtat_pkg::*;

   localparam int FLAG_MSB = FLAG_LSB + NUM_FLAGS - 1;

   if (HI_W < 1 || HI_W > BUS_W) begin : g_bad_hi
      $error("HI_W must be within 1..32");
   end
   if (LO_W < 1 || LO_W > BUS_W) begin : g_bad_lo
      $error("LO_W must be within 1..32");
   end
   if (PER_W < 1 || PER_W > BUS_W) begin : g_bad_per
      $error("PER_W must be within 1..32");
   end

   reg_addr_e sel;
   assign sel = reg_addr_e'(addr);

   logic wr_ctrl, wr_alm_hi, wr_alm_lo, wr_reload, wr_stat, wr_ien, rd_lo;
   assign wr_ctrl   = wr_en && (sel == A_CTRL);
   assign wr_alm_hi = wr_en && (sel == A_ALM_HI);
   assign wr_alm_lo = wr_en && (sel == A_ALM_LO);
   assign wr_reload = wr_en && (sel == A_RELOAD);
   assign wr_stat   = wr_en && (sel == A_STATUS);
   assign wr_ien    = wr_en && (sel == A_IRQEN);
   assign rd_lo     = rd_en && (sel == A_CNT_LO);

   ctrl_t                ctrl_q;
   logic [PER_W-1:0]     reload_q;
   logic [NUM_FLAGS-1:0] ien_q;
   logic [HI_W-1:0]      hi_shadow;

   logic [HI_W-1:0]      cnt_hi;
   logic [LO_W-1:0]      cnt_lo;
   logic [PER_W-1:0]     per_cnt;
   logic                 wrap, hit, tick;
   logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         reload_q  <= '0;
         ien_q     <= '0;
         hi_shadow <= '0;
      end else begin
         if (wr_ctrl)   ctrl_q    <= ctrl_t'(wdata[CTRL_W-1:0]);
         if (wr_reload) reload_q  <= wdata[PER_W-1:0];
         if (wr_ien)    ien_q     <= wdata[FLAG_MSB:FLAG_LSB];
         if (rd_lo)     hi_shadow <= cnt_hi;
      end
   end

   rtat_rtc_counter #(.HI_W(HI_W), .LO_W(LO_W)) u_rtc (
      .clk     (clk),
      .rst_n   (rst_n),
      .zero    (ctrl_q.zero),
      .hold_lo (ctrl_q.hold_lo),
      .hold_hi (ctrl_q.hold_hi),
      .cnt_hi  (cnt_hi),
      .cnt_lo  (cnt_lo),
      .wrap    (wrap)
   );

   rtat_alarm_cmp #(.HI_W(HI_W), .LO_W(LO_W)) u_alarm (
      .clk       (clk),
      .rst_n     (rst_n),
      .stage_hi  (wr_alm_hi),
      .commit_lo (wr_alm_lo),
      .wr_hi     (wdata[HI_W-1:0]),
      .wr_lo     (wdata[LO_W-1:0]),
      .cnt_hi    (cnt_hi),
      .cnt_lo    (cnt_lo),
      .hit       (hit)
   );

   rtat_periodic #(.PER_W(PER_W)) u_per (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ctrl_q.per_run),
      .hold   (ctrl_q.per_hold),
      .reload (reload_q),
      .cnt    (per_cnt),
      .tick   (tick)
   );

   always_comb begin
      flag_set          = '0;
      flag_set[F_TICK]  = tick;
      flag_set[F_ALARM] = hit;
      flag_set[F_WRAP]  = wrap;
      flag_clr          = wr_stat ? wdata[FLAG_MSB:FLAG_LSB] : '0;
   end

   rtat_irq_flags #(.N(NUM_FLAGS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (flag_set),
      .ack    (flag_clr),
      .enable (ien_q),
      .flags  (flags),
      .irq    (irq)
   );

   always_comb begin
      rdata = '0;
      unique case (sel)
         A_CTRL:   rdata[CTRL_W-1:0]        = ctrl_q;
         A_CNT_HI: rdata[HI_W-1:0]          = hi_shadow;
         A_CNT_LO: rdata[LO_W-1:0]          = cnt_lo;
         A_RELOAD: rdata[PER_W-1:0]         = reload_q;
         A_STATUS: rdata[FLAG_MSB:FLAG_LSB] = flags;
         A_IRQEN:  rdata[FLAG_MSB:FLAG_LSB] = ien_q;
         default:  rdata                    = '0;
      endcase
   end

endmodule

// File: rtl/rtat_checker.sv
module rtat_checker #(
   parameter int HI_W  = 8,
   parameter int LO_W  = 32,
   parameter int PER_W = 16
) (
   input logic                           clk,
   input logic                           rst_n,
   input rtat_pkg::ctrl_t                ctrl,
   input logic [HI_W-1:0]                cnt_hi,
   input logic [LO_W-1:0]                cnt_lo,
   input logic [PER_W-1:0]               per_cnt,
   input logic [rtat_pkg::NUM_FLAGS-1:0] flags,
   input logic [rtat_pkg::NUM_FLAGS-1:0] flag_clr,
   input logic [rtat_pkg::NUM_FLAGS-1:0] ien,
   input logic                           irq,
   input logic                           rd_lo,
   input logic [HI_W-1:0]                shadow
);
   import rtat_pkg::*;

   p_zero_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.zero |=> (cnt_hi == '0) && (cnt_lo == '0));

   p_lo_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.zero && ctrl.hold_lo) |=> $stable(cnt_lo));

   p_hi_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.zero && ctrl.hold_hi) |=> $stable(cnt_hi));

   p_wrap_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.zero && !ctrl.hold_lo && !ctrl.hold_hi && (&cnt_hi) && (&cnt_lo))
      |=> flags[F_WRAP]);

   p_per_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.per_run && ctrl.per_hold) |=> $stable(per_cnt));

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sticky
      p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !flag_clr[i]) |=> flags[i]);
   end

   p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0) |-> !irq);

   p_shadow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> (shadow == $past(cnt_hi)));

endmodule

bind rtc_alarm_timer rtat_checker #(.HI_W(HI_W), .LO_W(LO_W), .PER_W(PER_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl     (ctrl_q),
   .cnt_hi   (cnt_hi),
   .cnt_lo   (cnt_lo),
   .per_cnt  (per_cnt),
   .flags    (flags),
   .flag_clr (flag_clr),
   .ien      (ien_q),
   .irq      (irq),
   .rd_lo    (rd_lo),
   .shadow   (hi_shadow)
);

// File: tb/rtc_alarm_timer_tb_top.sv
`timescale 1ns/1ps
module rtc_alarm_timer_tb_top;

   localparam int HI_W  = 4;
   localparam int LO_W  = 8;
   localparam int PER_W = 8;

   localparam logic [2:0] AD_CTRL = 3'd0, AD_HI = 3'd1, AD_LO = 3'd2, AD_AHI = 3'd3,
                          AD_ALO = 3'd4, AD_PER = 3'd5, AD_STAT = 3'd6, AD_IEN = 3'd7;
   localparam int B_WRAP = 31, B_ALARM = 30, B_TICK = 29;
   localparam logic [31:0] ACK_ALL = 32'hE000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   rtc_alarm_timer #(.HI_W(HI_W), .LO_W(LO_W), .PER_W(PER_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(posedge clk);
      #1 rd_en = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      addr = AD_LO;   #1 chk("R1 low word", rdata, 0);
      addr = AD_STAT; #1 chk("R1 status", rdata, 0);
      addr = AD_CTRL; #1 chk("R1 control", rdata, 0);
      chk("R1 irq", {31'b0, irq}, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_clear();
      logic [31:0] v;
      wr(AD_CTRL, 32'h1);
      repeat (2) @(posedge clk);
      rd(AD_LO, v); chk("R4 cleared low", v, 0);
      repeat (5) @(posedge clk);
      rd(AD_LO, v); chk("R4 held low", v, 0);
      rd(AD_HI, v); chk("R4 held high", v, 0);
   endtask

   task automatic t_count();
      logic [31:0] v;
      wr(AD_CTRL, 32'h0);
      rd(AD_LO, v); chk("R4 first value after release", v, 0);
      repeat (9) @(posedge clk);
      rd(AD_LO, v); chk("R2 ten clocks later", v, 10);
   endtask

   task automatic t_shadow();
      logic [31:0] v;
      wr(AD_CTRL, 32'h1);
      repeat (2) @(posedge clk);
      wr(AD_CTRL, 32'h0);
      rd(AD_LO, v);
      repeat (254) @(posedge clk);
      rd(AD_LO, v); chk("R11 low at 255", v, 32'hFF);
      rd(AD_HI, v); chk("R11 high coherent with low", v, 0);
      rd(AD_LO, v); chk("R11 low after carry", v, 1);
      rd(AD_HI, v); chk("R11 high after carry", v, 1);
   endtask

   task automatic t_freeze();
      logic [31:0] a, b, h, c, d;
      wr(AD_CTRL, 32'h2);
      rd(AD_LO, a);
      repeat (20) @(posedge clk);
      rd(AD_LO, b); chk("R3 low frozen", b, a);
      rd(AD_HI, h);
      wr(AD_CTRL, 32'h4);
      rd(AD_LO, c);
      repeat (300) @(posedge clk);
      rd(AD_LO, d); chk("R3 low runs while high frozen", d, (c + 301) & 32'hFF);
      rd(AD_HI, d); chk("R3 high frozen", d, h);
   endtask

   task automatic t_release();
      logic [31:0] e, v;
      wr(AD_CTRL, 32'h1E);
      wr(AD_CTRL, 32'h0);
      rd(AD_CTRL, v); chk("R8 control reads zero", v, 0);
      rd(AD_LO, e);
      repeat (4) @(posedge clk);
      rd(AD_LO, v); chk("R8 counting resumes", v, (e + 5) & 32'hFF);
   endtask

   task automatic t_wrap();
      logic [31:0] v;
      wr(AD_CTRL, 32'h1);
      repeat (2) @(posedge clk);
      wr(AD_STAT, ACK_ALL);
      wr(AD_CTRL, 32'h0);
      rd(AD_STAT, v); chk("R5 no wrap at start", {31'b0, v[B_WRAP]}, 0);
      repeat (4094) @(posedge clk);
      rd(AD_STAT, v); chk("R5 no wrap at all ones", {31'b0, v[B_WRAP]}, 0);
      rd(AD_STAT, v); chk("R5 wrap flag", {31'b0, v[B_WRAP]}, 1);
      repeat (50) @(posedge clk);
      rd(AD_STAT, v); chk("R9 wrap flag sticky", {31'b0, v[B_WRAP]}, 1);
   endtask

   task automatic t_alarm();
      logic [31:0] v;
      wr(AD_CTRL, 32'h1);
      wr(AD_AHI, 32'h0);
      wr(AD_ALO, 32'h40);
      wr(AD_AHI, 32'h1);
      wr(AD_STAT, ACK_ALL);
      wr(AD_CTRL, 32'h0);
      rd(AD_STAT, v); chk("R6 no alarm at start", {31'b0, v[B_ALARM]}, 0);
      repeat (63) @(posedge clk);
      rd(AD_STAT, v); chk("R6 alarm not yet set", {31'b0, v[B_ALARM]}, 0);
      rd(AD_STAT, v); chk("R6 alarm after match, staged high ignored", {31'b0, v[B_ALARM]}, 1);
   endtask

   task automatic t_periodic();
      logic [31:0] v;
      wr(AD_STAT, ACK_ALL);
      wr(AD_PER, 32'd9);
      rd(AD_PER, v); chk("R7 reload readback", v, 9);
      wr(AD_CTRL, 32'h8);
      rd(AD_STAT, v);
      repeat (8) @(posedge clk);
      rd(AD_STAT, v); chk("R7 no tick before period", {31'b0, v[B_TICK]}, 0);
      rd(AD_STAT, v); chk("R7 first tick", {31'b0, v[B_TICK]}, 1);
      wr(AD_STAT, 32'h2000_0000);
      rd(AD_STAT, v); chk("R9 tick cleared by write-one", {31'b0, v[B_TICK]}, 0);
      repeat (6) @(posedge clk);
      rd(AD_STAT, v); chk("R7 no tick mid period", {31'b0, v[B_TICK]}, 0);
      rd(AD_STAT, v); chk("R7 second tick", {31'b0, v[B_TICK]}, 1);
      wr(AD_CTRL, 32'h18);
      wr(AD_STAT, ACK_ALL);
      repeat (30) @(posedge clk);
      rd(AD_STAT, v); chk("R7 paused timer no tick", {31'b0, v[B_TICK]}, 0);
      wr(AD_CTRL, 32'h0);
      wr(AD_STAT, ACK_ALL);
      repeat (30) @(posedge clk);
      rd(AD_STAT, v); chk("R8 periodic disabled", {31'b0, v[B_TICK]}, 0);
   endtask

   task automatic t_set_wins();
      logic [31:0] v;
      wr(AD_PER, 32'd0);
      wr(AD_CTRL, 32'h8);
      repeat (3) @(posedge clk);
      wr(AD_STAT, 32'h2000_0000);
      rd(AD_STAT, v); chk("R9 event beats clear", {31'b0, v[B_TICK]}, 1);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      wr(AD_IEN, 32'h0);
      @(negedge clk); chk("R10 irq masked", {31'b0, irq}, 0);
      wr(AD_IEN, 32'h2000_0000);
      @(negedge clk); chk("R10 irq on enabled flag", {31'b0, irq}, 1);
      rd(AD_IEN, v); chk("R10 enable readback", v, 32'h2000_0000);
      wr(AD_STAT, 32'h8000_0000);
      wr(AD_IEN, 32'h8000_0000);
      @(negedge clk); chk("R10 irq ignores unmasked flag", {31'b0, irq}, 0);
      wr(AD_CTRL, 32'h0);
   endtask

   initial begin
      t_reset();
      t_clear();
      t_count();
      t_shadow();
      t_freeze();
      t_release();
      t_wrap();
      t_alarm();
      t_periodic();
      t_set_wins();
      t_irq();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule